// File: doc/BRIEF.md
# Masked Exception Request Arbiter

This block keeps a pending flag for each of four asynchronous exception sources: normal interrupt (source 0), fast interrupt (source 1), asynchronous abort (source 2) and reset (source 3). Agents raise or lower one flag per cycle through a post port and a clear port. Each port carries a source number and a sub-index. A clear-all input wipes every flag. A second register, the status word, mirrors the flags with one bit per source.

Three mask bits from the processor status register gate the sources. The I bit masks the normal interrupt, F masks the fast interrupt and A masks the abort. Reset cannot be masked. From the registered flags and the live masks, the block combinationally drives a pending line, a one-hot selection and an encoded selection of the exception the core should take next. Priority is fixed.

A load port writes all four flags at once, and a snapshot output shows the stored flags. Together they let the state be saved and restored. A registered error pulse reports requests that are malformed. A consistency flag reports any disagreement between the status word and the flags.

Top module: `exc_req_arbiter`

## Requirements
- R1: A post request with source number 0..3 and sub-index 0 sets that source's flag at the next clock edge. The flag shows on `snap_flags[src]`.
- R2: A legal clear request resets that source's flag at the next edge. If a legal post and a legal clear name the same source in the same cycle, the flag ends cleared.
- R3: A post or clear request is illegal if its source number is 4 or greater, or if its sub-index is not 0. An illegal request sets `bad_req` high for exactly the cycle after it and changes no flag.
- R4: While `clr_all` is high, every flag and the status word become 0 at the edge. This takes precedence over load, post and clear. Synchronous reset (`rst_n` low) has the same effect and also clears `bad_req`.
- R5: The normal interrupt is eligible only when `mask_i` is 0. The fast interrupt is eligible only when `mask_f` is 0. The abort is eligible only when `mask_a` is 0.
- R6: A pending reset flag is eligible whatever the mask bits are.
- R7: When several sources are eligible, the selection follows a fixed order. The normal interrupt wins, then the fast interrupt, then the abort, then reset. `exc_onehot` has bit k set for selected source k.
- R8: `exc_pend` is 1 exactly when the status word is nonzero and at least one source is eligible. In every other case `exc_code` is 0 (no exception) and `exc_onehot` is 0.
- R9: `exc_code` is 1 for normal interrupt, 2 for fast interrupt, 3 for asynchronous external abort and 4 for reset.
- R10: When `ld_en` is high and `clr_all` is low, the flags and the status word take `ld_flags` at the edge, and post and clear have no effect in that cycle.
- R11: `sync_err` is 1 only when the status word differs from the flags. In correct operation it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_vld | input | 1 | Post request valid |
| post_src | input | 3 | Post source number |
| post_sub | input | 2 | Post sub-index (must be 0) |
| clr_vld | input | 1 | Clear request valid |
| clr_src | input | 3 | Clear source number |
| clr_sub | input | 2 | Clear sub-index (must be 0) |
| clr_all | input | 1 | Clear every flag |
| mask_i | input | 1 | Normal interrupt mask |
| mask_f | input | 1 | Fast interrupt mask |
| mask_a | input | 1 | Abort mask |
| ld_en | input | 1 | Load flags from ld_flags |
| ld_flags | input | 4 | Flag values to load |
| exc_pend | output | 1 | An eligible exception is pending |
| exc_onehot | output | 4 | One-hot selected source |
| exc_code | output | 3 | Encoded selected exception |
| bad_req | output | 1 | Illegal request seen in the previous cycle |
| sync_err | output | 1 | Status word and flags disagree |
| snap_flags | output | 4 | Registered flag snapshot |

## Verification
Flag changes from post, clear, clear-all and load show on `snap_flags` one edge after the request. `bad_req` is due in that same cycle. The selection outputs `exc_pend`, `exc_onehot` and `exc_code` follow the masks with no delay, but they follow the flags one edge after a flag update. For this reason the bench drives every stimulus just after a rising edge and samples one time unit after the next edge, so each registered result falls exactly in its sampling window. Selection checks change the masks and sample again before the next edge, which covers the combinational path without a clock.

// File: rtl/exc_arb_pkg.sv
// Package: shared sizes and the exception selection encoding.
// Assumes four sources, numbered in priority order (0 highest).
package exc_arb_pkg;
    localparam int NUM_SRC = 4;
    localparam int SRC_W   = 3;
    localparam int SUB_W   = 2;
    localparam int CODE_W  = 3;

    typedef enum logic [CODE_W-1:0] {
        EXC_NONE      = 3'd0,
        EXC_IRQ       = 3'd1,
        EXC_FIQ       = 3'd2,
        EXC_ASYNC_ABT = 3'd3,
        EXC_RESET     = 3'd4
    } exc_code_e;
endpackage

// File: rtl/exc_pend_store.sv
// Module: pending flag storage with its mirrored status word.
// Applies post, clear, clear-all and load, and flags illegal requests.
// Assumes at most one post and one clear per cycle, and synchronous active-low reset.
module exc_pend_store #(
    parameter int NSRC = exc_arb_pkg::NUM_SRC,
    parameter int SW   = exc_arb_pkg::SRC_W,
    parameter int UW   = exc_arb_pkg::SUB_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            post_vld,
    input  logic [SW-1:0]   post_src,
    input  logic [UW-1:0]   post_sub,
    input  logic            clr_vld,
    input  logic [SW-1:0]   clr_src,
    input  logic [UW-1:0]   clr_sub,
    input  logic            clr_all,
    input  logic            ld_en,
    input  logic [NSRC-1:0] ld_flags,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] status,
    output logic            bad_req
);
    localparam logic [SW-1:0] SRC_LIMIT = SW'(NSRC);

    logic            post_ok, clr_ok, post_bad, clr_bad;
    logic [NSRC-1:0] post_hit, clr_hit, nxt_flags;

    // Decode legality of each request port.
    always_comb begin
        post_ok  = post_vld && (post_src < SRC_LIMIT) && (post_sub == '0);
        clr_ok   = clr_vld  && (clr_src  < SRC_LIMIT) && (clr_sub  == '0);
        post_bad = post_vld && !post_ok;
        clr_bad  = clr_vld  && !clr_ok;
    end

    // Per-source next flag value; a clear overrides a post on the same source.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign post_hit[g]  = post_ok && (post_src == SW'(g));
        assign clr_hit[g]   = clr_ok  && (clr_src  == SW'(g));
        assign nxt_flags[g] = (flags[g] | post_hit[g]) & ~clr_hit[g];
    end

    // Register flags, status word and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags   <= '0;
            status  <= '0;
            bad_req <= 1'b0;
        end else begin
            bad_req <= post_bad || clr_bad;
            if (clr_all) begin
                flags  <= '0;
                status <= '0;
            end else if (ld_en) begin
                flags  <= ld_flags;
                status <= ld_flags;
            end else begin
                flags  <= nxt_flags;
                status <= nxt_flags;
            end
        end
    end

    // R1
    post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_ok && !clr_all && !ld_en && !(clr_ok && clr_src == post_src))
        |=> flags[$past(post_src)]);

    // R2
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && !clr_all && !ld_en) |=> !flags[$past(clr_src)]);

    // R3
    bad_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((post_bad || !post_vld) && (clr_bad || !clr_vld) && !clr_all && !ld_en)
        |=> $stable(flags));

    // R4
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (flags == '0 && status == '0));
endmodule

// File: rtl/exc_mask_select.sv
// Module: masking and fixed-priority selection of the pending exception.
// Purely combinational from the registered flags and the live mask bits.
// Assumes source index equals priority rank (0 highest) and that reset is the last source.
module exc_mask_select #(
    parameter int NSRC = exc_arb_pkg::NUM_SRC,
    parameter int CW   = exc_arb_pkg::CODE_W
) (
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] status,
    input  logic            mask_i,
    input  logic            mask_f,
    input  logic            mask_a,
    output logic            pend,
    output logic [NSRC-1:0] onehot,
    output logic [CW-1:0]   code,
    output logic            sync_err
);
    import exc_arb_pkg::*;

    logic [NSRC-1:0] mask_vec, elig;

    // Build the per-source mask; reset (last source) is never masked.
    always_comb begin
        mask_vec         = '0;
        mask_vec[0]      = mask_i;
        mask_vec[1]      = mask_f;
        mask_vec[2]      = mask_a;
        mask_vec[NSRC-1] = 1'b0;
        elig             = flags & ~mask_vec;
    end

    // Pick the lowest-index eligible source and encode it.
    always_comb begin
        onehot = '0;
        code   = EXC_NONE;
        if (status != '0) begin
            for (int k = NSRC - 1; k >= 0; k--) begin
                if (elig[k]) begin
                    onehot    = '0;
                    onehot[k] = 1'b1;
                    code      = CW'(k + 1);
                end
            end
        end
        pend     = (status != '0) && (elig != '0);
        sync_err = (status != flags);
    end

    // R7
    onehot_sel_chk: assert final ($onehot0(onehot));

    // R6
    reset_unmasked_chk: assert final (!(flags == 4'b1000 && status == flags) || code == EXC_RESET);

    // R8
    pend_code_chk: assert final (pend == (code != EXC_NONE));
endmodule

// File: rtl/exc_req_arbiter.sv
// Module: top of the masked exception request arbiter.
// Joins the flag store and the selector, and exposes the snapshot.
// Assumes synchronous active-low reset and masks stable around the clock edge.
module exc_req_arbiter #(
    parameter int NSRC = exc_arb_pkg::NUM_SRC,
    parameter int SW   = exc_arb_pkg::SRC_W,
    parameter int UW   = exc_arb_pkg::SUB_W,
    parameter int CW   = exc_arb_pkg::CODE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            post_vld,
    input  logic [SW-1:0]   post_src,
    input  logic [UW-1:0]   post_sub,
    input  logic            clr_vld,
    input  logic [SW-1:0]   clr_src,
    input  logic [UW-1:0]   clr_sub,
    input  logic            clr_all,
    input  logic            mask_i,
    input  logic            mask_f,
    input  logic            mask_a,
    input  logic            ld_en,
    input  logic [NSRC-1:0] ld_flags,
    output logic            exc_pend,
    output logic [NSRC-1:0] exc_onehot,
    output logic [CW-1:0]   exc_code,
    output logic            bad_req,
    output logic            sync_err,
    output logic [NSRC-1:0] snap_flags
);
    logic [NSRC-1:0] flags, status;

    exc_pend_store #(.NSRC(NSRC), .SW(SW), .UW(UW)) i_store (
        .clk(clk), .rst_n(rst_n),
        .post_vld(post_vld), .post_src(post_src), .post_sub(post_sub),
        .clr_vld(clr_vld), .clr_src(clr_src), .clr_sub(clr_sub),
        .clr_all(clr_all), .ld_en(ld_en), .ld_flags(ld_flags),
        .flags(flags), .status(status), .bad_req(bad_req)
    );

    exc_mask_select #(.NSRC(NSRC), .CW(CW)) i_sel (
        .flags(flags), .status(status),
        .mask_i(mask_i), .mask_f(mask_f), .mask_a(mask_a),
        .pend(exc_pend), .onehot(exc_onehot), .code(exc_code),
        .sync_err(sync_err)
    );

    // Snapshot is the registered flag vector itself.
    assign snap_flags = flags;

    // R11
    status_sync_chk: assert property (@(posedge clk) disable iff (!rst_n) !sync_err);

    // R10
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !clr_all) |=> (snap_flags == $past(ld_flags)));
endmodule

// File: tb/test_exc_req_arbiter.sv
module test_exc_req_arbiter;
    logic clk = 1'b0;
    logic rst_n;
    logic post_vld, clr_vld, clr_all, mask_i, mask_f, mask_a, ld_en;
    logic [2:0] post_src, clr_src;
    logic [1:0] post_sub, clr_sub;
    logic [3:0] ld_flags;
    logic exc_pend, bad_req, sync_err;
    logic [3:0] exc_onehot, snap_flags;
    logic [2:0] exc_code;

    int tests = 0;
    int fails = 0;
    logic [3:0] model;

    always #5 clk = ~clk;

    exc_req_arbiter i_exc_req_arbiter (
        .clk(clk), .rst_n(rst_n),
        .post_vld(post_vld), .post_src(post_src), .post_sub(post_sub),
        .clr_vld(clr_vld), .clr_src(clr_src), .clr_sub(clr_sub),
        .clr_all(clr_all), .mask_i(mask_i), .mask_f(mask_f), .mask_a(mask_a),
        .ld_en(ld_en), .ld_flags(ld_flags),
        .exc_pend(exc_pend), .exc_onehot(exc_onehot), .exc_code(exc_code),
        .bad_req(bad_req), .sync_err(sync_err), .snap_flags(snap_flags)
    );

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        post_vld = 0; clr_vld = 0; clr_all = 0; ld_en = 0;
        post_src = 0; clr_src = 0; post_sub = 0; clr_sub = 0; ld_flags = 0;
    endtask

    // One edge, then sample one unit after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Check the selector against an arithmetic model of R5..R9.
    task automatic check_sel(logic [3:0] fl, logic mi, logic mf, logic ma);
        logic [3:0] el;
        int sel;
        el  = fl & ~{1'b0, ma, mf, mi};
        sel = -1;
        for (int k = 3; k >= 0; k--) if (el[k]) sel = k;
        check("R8 pend", int'(exc_pend), int'(sel >= 0));
        check("R7 onehot", int'(exc_onehot), (sel >= 0) ? (1 << sel) : 0);
        check("R9 code", int'(exc_code), sel + 1);
        check("R11 sync", int'(sync_err), 0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle();
        mask_i = 0; mask_f = 0; mask_a = 0;
        rst_n = 0;
        step(); step();
        check("R4 reset flags", int'(snap_flags), 0);
        check("R4 reset bad", int'(bad_req), 0);
        check("R8 reset code", int'(exc_code), 0);
        rst_n = 1;

        // R10 / R5 / R6 / R7: load every flag pattern, sweep every mask.
        for (int p = 0; p < 16; p++) begin
            ld_en = 1; ld_flags = 4'(p);
            step();
            idle();
            check("R10 load", int'(snap_flags), p);
            for (int m = 0; m < 8; m++) begin
                mask_i = m[0]; mask_f = m[1]; mask_a = m[2];
                #1;
                check_sel(4'(p), m[0], m[1], m[2]);
            end
        end
        mask_i = 0; mask_f = 0; mask_a = 0;

        // R10: load has priority over a post in the same cycle.
        ld_en = 1; ld_flags = 4'b0000; post_vld = 1; post_src = 3'd2;
        step(); idle();
        check("R10 load beats post", int'(snap_flags), 0);
        model = 4'b0000;

        // R1 / R2 / R3: sweep all source numbers and sub-indices.
        for (int s = 0; s < 8; s++) begin
            for (int u = 0; u < 4; u++) begin
                logic legal;
                legal = (s < 4) && (u == 0);
                post_vld = 1; post_src = 3'(s); post_sub = 2'(u);
                step(); idle();
                if (legal) model[s] = 1'b1;
                check("R1/R3 post flags", int'(snap_flags), int'(model));
                check("R3 post bad", int'(bad_req), int'(!legal));
                step();
                check("R3 bad one cycle", int'(bad_req), 0);
                clr_vld = 1; clr_src = 3'(s); clr_sub = 2'(u);
                step(); idle();
                if (legal) model[s] = 1'b0;
                check("R2/R3 clear flags", int'(snap_flags), int'(model));
                check("R3 clear bad", int'(bad_req), int'(!legal));
            end
        end

        // R3: illegal request leaves existing flags untouched.
        ld_en = 1; ld_flags = 4'b1010; step(); idle();
        post_vld = 1; post_src = 3'd5; clr_vld = 1; clr_src = 3'd1; clr_sub = 2'd2;
        step(); idle();
        check("R3 state kept", int'(snap_flags), 4'b1010);
        check("R3 bad both", int'(bad_req), 1);

        // R2: post and clear on the same source, clear wins.
        for (int s = 0; s < 4; s++) begin
            ld_en = 1; ld_flags = 4'b0000; step(); idle();
            post_vld = 1; post_src = 3'(s); clr_vld = 1; clr_src = 3'(s);
            step(); idle();
            check("R2 clear wins", int'(snap_flags), 0);
        end

        // R4: clear-all beats load and post.
        ld_en = 1; ld_flags = 4'b1111; step(); idle();
        clr_all = 1; ld_en = 1; ld_flags = 4'b0110; post_vld = 1; post_src = 3'd3;
        step(); idle();
        check("R4 clear all", int'(snap_flags), 0);
        check("R8 after clear all", int'(exc_pend), 0);

        // R6: reset pending with all masks set.
        mask_i = 1; mask_f = 1; mask_a = 1;
        post_vld = 1; post_src = 3'd3; step(); idle();
        check("R6 reset unmasked code", int'(exc_code), 4);
        check("R6 reset unmasked pend", int'(exc_pend), 1);

        // R4: synchronous reset in mid-run.
        post_vld = 1; post_src = 3'd3; rst_n = 0; step(); idle();
        check("R4 rst mid run", int'(snap_flags), 0);
        rst_n = 1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule